// File: doc/BRIEF.md
# Reorder-Buffer Visibility Point Tracker

This block looks at the status of a circular reorder buffer (ROB) and finds the visibility point. The visibility point is the youngest occupied entry that is no longer speculative. Every occupied entry from the head up to and including that point is reported as safe. Every occupied entry younger than it is transient. Taint logic uses the per-entry safe vector to decide when a load result may be untainted. Loads that sit past the visibility point are unsafe.

The block takes the head and tail pointers and three per-entry hazard flags: unresolved control transfer, possible exception, and unresolved memory ordering. It also takes a one-bit mode. In control-only mode, only unresolved branches and jumps make younger entries speculative. In full mode, possible exceptions and unresolved memory-ordering or consistency hazards do so as well.

All inputs are captured in one register stage, and the scan is computed from those registers. A change at the inputs is therefore visible at the outputs one clock later. Allocation, commit and flush are handled by the surrounding pipeline.

Top module: `vis_point_tracker`

## Requirements
- R1: While reset is high and directly after it, `vp_valid` is 0, `vp_idx` is 0 and `safe_vec` is all zeros.
- R2: When the registered head and tail pointers are equal in all bits (an empty ROB), `vp_valid` is 0, `vp_idx` is 0 and `safe_vec` is all zeros, whatever the flags hold.
- R3: With `mode_full`=0, an occupied entry blocks only if its `br_pend` bit is set. `vp_idx` is the first blocking entry found when scanning from the head toward the tail. Set `exc_pend` and `mord_pend` bits have no effect in this mode.
- R4: With `mode_full`=1, an occupied entry blocks if any of its `br_pend`, `exc_pend` or `mord_pend` bits is set. `vp_idx` is the first such entry from the head.
- R5: When no occupied entry blocks, `vp_idx` is the youngest occupied entry, at index (tail − 1) mod DEPTH, and every occupied entry is safe.
- R6: `safe_vec[i]` is 1 exactly for the entries from the head through `vp_idx` inclusive, in circular order. All other bits are 0.
- R7: Flag bits of unoccupied entries have no effect on any output.
- R8: The pointers are IDX_W+1 bits wide, with the top bit as a wrap bit. When the low bits are equal and the wrap bits differ, all DEPTH entries are occupied.
- R9: The outputs reflect the inputs sampled at the previous rising clock edge. A change of `mode_full` takes effect one cycle after it is applied.
- R10: Occupancy that wraps past index DEPTH−1 back to index 0 is scanned in age order, starting from the head.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_full | input | 1 | 0: control-only speculation; 1: full speculation |
| head_ptr | input | IDX_W+1 | Oldest entry; top bit is the wrap bit |
| tail_ptr | input | IDX_W+1 | Next free slot; top bit is the wrap bit |
| br_pend | input | DEPTH | Per entry: unresolved branch or jump |
| exc_pend | input | DEPTH | Per entry: may still raise an exception |
| mord_pend | input | DEPTH | Per entry: memory-ordering or consistency hazard unresolved |
| vp_valid | output | 1 | ROB not empty, so `vp_idx` is meaningful |
| vp_idx | output | IDX_W | Index of the visibility point |
| safe_vec | output | DEPTH | Per entry: non-speculative |

DEPTH must be a power of two and at least 2. IDX_W = log2(DEPTH).

## Verification
Every result is due exactly one rising edge after the stimulus that produces it, because there is a single input register stage. The bench drives a new stimulus 2 ns after a rising edge, waits for the next rising edge, and samples 2 ns later. For the mode change, the bench also samples before the edge, to confirm that the old result still holds, and again after the edge, to confirm the new one. A four-entry configuration is swept over every head position and occupancy in both modes, using pseudo-random flags. Wrapped full-buffer cases are swept exhaustively over the branch and exception flags.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  typedef enum logic {
    SPEC_CTRL = 1'b0,
    SPEC_ALL  = 1'b1
  } spec_mode_e;
endpackage

// File: rtl/vpt_in_stage.sv
module vpt_in_stage #(
  parameter int DEPTH = 8,
  parameter int PTR_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode_in,
  input  logic [PTR_W-1:0]    head_in,
  input  logic [PTR_W-1:0]    tail_in,
  input  logic [DEPTH-1:0]    br_in,
  input  logic [DEPTH-1:0]    exc_in,
  input  logic [DEPTH-1:0]    mord_in,
  output vpt_pkg::spec_mode_e mode_q,
  output logic [PTR_W-1:0]    head_q,
  output logic [PTR_W-1:0]    tail_q,
  output logic [DEPTH-1:0]    br_q,
  output logic [DEPTH-1:0]    exc_q,
  output logic [DEPTH-1:0]    mord_q
);
  // Single capture stage; everything downstream is derived from these
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= vpt_pkg::SPEC_CTRL;
      head_q <= '0;
      tail_q <= '0;
      br_q   <= '0;
      exc_q  <= '0;
      mord_q <= '0;
    end else begin
      mode_q <= vpt_pkg::spec_mode_e'(mode_in);
      head_q <= head_in;
      tail_q <= tail_in;
      br_q   <= br_in;
      exc_q  <= exc_in;
      mord_q <= mord_in;
    end
  end
endmodule

// File: rtl/vpt_block_mask.sv
module vpt_block_mask #(
  parameter int DEPTH = 8
) (
  input  vpt_pkg::spec_mode_e mode,
  input  logic [DEPTH-1:0]    br,
  input  logic [DEPTH-1:0]    exc,
  input  logic [DEPTH-1:0]    mord,
  output logic [DEPTH-1:0]    blk
);
  logic wide;
  assign wide = (mode == vpt_pkg::SPEC_ALL);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign blk[i] = br[i] | (wide & (exc[i] | mord[i]));
  end
endmodule

// File: rtl/vpt_scan.sv
module vpt_scan #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int PTR_W = 4
) (
  input  logic [PTR_W-1:0] head,
  input  logic [PTR_W-1:0] tail,
  input  logic [DEPTH-1:0] blk,
  output logic             valid,
  output logic [IDX_W-1:0] idx,
  output logic [DEPTH-1:0] safe
);
  logic [PTR_W-1:0] occ;
  assign occ   = tail - head;
  assign valid = (occ != '0);

  // Walk in age order; the first blocking entry is the last safe one
  always_comb begin
    logic             stop;
    logic [IDX_W-1:0] pos;
    stop = 1'b0;
    safe = '0;
    idx  = '0;
    for (int k = 0; k < DEPTH; k++) begin
      pos = head[IDX_W-1:0] + IDX_W'(k);
      if ((PTR_W'(k) < occ) && !stop) begin
        safe[pos] = 1'b1;
        idx       = pos;
        stop      = blk[pos];
      end
    end
  end
endmodule

// File: rtl/vis_point_tracker.sv
module vis_point_tracker #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_full,
  input  logic [PTR_W-1:0] head_ptr,
  input  logic [PTR_W-1:0] tail_ptr,
  input  logic [DEPTH-1:0] br_pend,
  input  logic [DEPTH-1:0] exc_pend,
  input  logic [DEPTH-1:0] mord_pend,
  output logic             vp_valid,
  output logic [IDX_W-1:0] vp_idx,
  output logic [DEPTH-1:0] safe_vec
);
  vpt_pkg::spec_mode_e mode_q;
  logic [PTR_W-1:0] head_q, tail_q;
  logic [DEPTH-1:0] br_q, exc_q, mord_q, blk;

  vpt_in_stage #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_in (
    .clk(clk), .rst(rst), .mode_in(mode_full),
    .head_in(head_ptr), .tail_in(tail_ptr),
    .br_in(br_pend), .exc_in(exc_pend), .mord_in(mord_pend),
    .mode_q(mode_q), .head_q(head_q), .tail_q(tail_q),
    .br_q(br_q), .exc_q(exc_q), .mord_q(mord_q)
  );

  vpt_block_mask #(.DEPTH(DEPTH)) u_mask (
    .mode(mode_q), .br(br_q), .exc(exc_q), .mord(mord_q), .blk(blk)
  );

  vpt_scan #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PTR_W(PTR_W)) u_scan (
    .head(head_q), .tail(tail_q), .blk(blk),
    .valid(vp_valid), .idx(vp_idx), .safe(safe_vec)
  );

  assert_empty_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (head_q == tail_q) |-> (!vp_valid && safe_vec == '0 && vp_idx == '0));

  assert_head_and_vp_safe_R6: assert property (@(posedge clk) disable iff (rst)
    vp_valid |-> (safe_vec[vp_idx] && safe_vec[head_q[IDX_W-1:0]]));

  assert_head_block_stops_R3: assert property (@(posedge clk) disable iff (rst)
    (vp_valid && blk[head_q[IDX_W-1:0]]) |->
      ($countones(safe_vec) == 1 && vp_idx == head_q[IDX_W-1:0]));

  assert_one_cycle_latency_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (vp_valid == ($past(head_ptr) != $past(tail_ptr))));

  assert_full_all_safe_R8: assert property (@(posedge clk) disable iff (rst)
    ((head_q ^ tail_q) == {1'b1, {IDX_W{1'b0}}} && blk == '0) |-> (&safe_vec));
endmodule

// File: tb/vis_point_tracker_tb_top.sv
`timescale 1ns/1ps
module vis_point_tracker_tb_top;
  localparam int D  = 4;
  localparam int IW = 2;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_full = 1'b0;
  logic [PW-1:0] head_ptr = '0, tail_ptr = '0;
  logic [D-1:0] br_pend = '0, exc_pend = '0, mord_pend = '0;
  logic vp_valid;
  logic [IW-1:0] vp_idx;
  logic [D-1:0] safe_vec;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #5 clk = ~clk;

  vis_point_tracker #(.DEPTH(D)) dut_i (
    .clk(clk), .rst(rst), .mode_full(mode_full),
    .head_ptr(head_ptr), .tail_ptr(tail_ptr),
    .br_pend(br_pend), .exc_pend(exc_pend), .mord_pend(mord_pend),
    .vp_valid(vp_valid), .vp_idx(vp_idx), .safe_vec(safe_vec)
  );

  task automatic expect_of(input logic m, input logic [PW-1:0] h, input logic [PW-1:0] t,
                           input logic [D-1:0] b, input logic [D-1:0] e, input logic [D-1:0] o,
                           output logic ev, output logic [IW-1:0] ei, output logic [D-1:0] es);
    int cnt;
    int p;
    cnt = (int'(t) - int'(h) + 8) % 8;
    ev = (cnt != 0);
    ei = '0;
    es = '0;
    for (int k = 0; k < cnt; k++) begin
      p = (int'(h) + k) % D;
      es[p] = 1'b1;
      ei = IW'(p);
      if (b[p] || (m && (e[p] || o[p]))) break;
    end
  endtask

  task automatic check(input string tag, input logic ev, input logic [IW-1:0] ei,
                       input logic [D-1:0] es);
    total++;
    if (vp_valid !== ev) begin
      bad++; $display("FAIL %s valid got=%0b exp=%0b", tag, vp_valid, ev);
    end
    total++;
    if (vp_idx !== ei) begin
      bad++; $display("FAIL %s vp_idx got=%0d exp=%0d", tag, vp_idx, ei);
    end
    total++;
    if (safe_vec !== es) begin
      bad++; $display("FAIL %s safe_vec got=%b exp=%b", tag, safe_vec, es);
    end
  endtask

  task automatic apply(input string tag, input logic m, input logic [PW-1:0] h,
                       input logic [PW-1:0] t, input logic [D-1:0] b,
                       input logic [D-1:0] e, input logic [D-1:0] o);
    logic ev; logic [IW-1:0] ei; logic [D-1:0] es;
    mode_full = m; head_ptr = h; tail_ptr = t;
    br_pend = b; exc_pend = e; mord_pend = o;
    expect_of(m, h, t, b, e, o, ev, ei, es);
    @(posedge clk); #2;
    check(tag, ev, ei, es);
  endtask

  initial begin
    #1_900_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset", 1'b0, '0, '0);
    rst = 1'b0;
    @(posedge clk); #2;
    check("R1 after reset", 1'b0, '0, '0);

    apply("R2 empty with flags", 1'b1, 3'd6, 3'd6, 4'hF, 4'hF, 4'hF);
    apply("R7 unoccupied flags", 1'b1, 3'd1, 3'd3, 4'b1001, 4'b1001, 4'b1001);
    apply("R5 nothing blocks", 1'b1, 3'd2, 3'd5, 4'h0, 4'h0, 4'h0);
    apply("R3 exc ignored ctrl mode", 1'b0, 3'd0, 3'd4, 4'b0100, 4'hF, 4'hF);
    apply("R4 mord blocks full mode", 1'b1, 3'd0, 3'd4, 4'h0, 4'h0, 4'b0010);
    apply("R8 full wrapped", 1'b0, 3'd3, 3'd7, 4'h0, 4'hF, 4'h0);

    // R9: mode switch seen only after the next edge
    apply("R9 before switch", 1'b0, 3'd0, 3'd2, 4'h0, 4'b0001, 4'h0);
    mode_full = 1'b1;
    #1;
    check("R9 mode not yet applied", 1'b1, 2'd1, 4'b0011);
    @(posedge clk); #2;
    check("R9 mode applied", 1'b1, 2'd0, 4'b0001);

    // R3/R4/R6: every head position and occupancy, both modes
    for (int h = 0; h < 8; h++)
      for (int c = 0; c <= D; c++)
        for (int m = 0; m < 2; m++)
          for (int n = 0; n < 40; n++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            apply(m ? "R4 R6 sweep" : "R3 R6 sweep", m[0], PW'(h), PW'(h + c),
                  lcg[19:16], lcg[23:20], lcg[27:24]);
          end

    // R10/R8: wrapped full buffer, exhaustive over branch and exception flags
    for (int m = 0; m < 2; m++)
      for (int f = 0; f < 256; f++)
        apply("R10 R8 wrap full", m[0], 3'd5, 3'd1, f[3:0], f[7:4], 4'h0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule